// File: doc/BRIEF.md
# Prefixed bit manipulation unit

This unit executes the second byte of the prefixed bit-operation instruction group on one 8-bit operand that has already been fetched. The opcode byte selects one of four groups. The first group holds eight shift and rotate variants. The other three test, clear or set a single bit. The unit also takes the current flag nibble. It returns the result byte, a write-back enable and the new flag nibble.

The result is registered, so it appears one clock after the request. The surrounding pipeline fetches the operand from a register or from memory, passes it in with `valid_i`, and writes `result_o` back only while `wb_en_o` is high. The register-select field in opcode bits 2:0 is not used here, because the operand arrives already fetched.

Top module: `bitop_unit`

## Requirements
- R1: The opcode byte is decoded as group = bits 7:6, field = bits 5:3. The groups are: 00 shift/rotate with the field choosing the variant; 01 bit test; 10 bit clear; 11 bit set. In the last three groups the field is the bit index.
- R2: Shift-group fields 0 and 1 rotate left and right. The bit that leaves the byte re-enters at the opposite end.
- R3: Shift-group fields 2 and 3 rotate left and right through carry. The incoming C fills the vacated bit.
- R4: Field 4 shifts left and fills bit 0 with 0. Field 5 shifts right and keeps bit 7. Field 7 shifts right and fills bit 7 with 0.
- R5: For fields 0 to 5 and 7, C takes the bit shifted out (bit 7 for left moves, bit 0 for right moves), N and H are cleared, and Z is set exactly when the result is zero. The flag nibble is laid out as bit 3 Z, bit 2 N, bit 1 H, bit 0 C.
- R6: Field 6 exchanges the two nibbles, clears N, H and C, and sets Z when the result is zero.
- R7: Bit test sets Z to the inverse of the indexed operand bit, clears N, sets H and keeps C. It drives `wb_en_o` low, and `result_o` equals the operand.
- R8: Bit clear and bit set change only the indexed bit, leave all four flags as given, and drive `wb_en_o` high.
- R9: A request accepted on a clock edge produces its result, flags and `valid_o` high on that same edge, so they are visible for the following cycle.
- R10: In a cycle without `valid_i`, the next edge drives `valid_o` and `wb_en_o` low and leaves `result_o` and `flags_o` unchanged.
- R11: While `rst_ni` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| opcode_i | input | 8 | Second opcode byte |
| operand_i | input | DATA_W | Operand value |
| flags_i | input | 4 | Current flags {Z,N,H,C} |
| valid_o | output | 1 | Result valid |
| result_o | output | DATA_W | Result byte |
| wb_en_o | output | 1 | Write-back enable |
| flags_o | output | 4 | New flags {Z,N,H,C} |

## Verification
Within a single operation, the rotate-through-carry variants both consume the old C and produce a new C. A defect that mixes up these two uses shows only when the incoming C differs from the outgoing bit. The bench therefore sweeps every opcode against every operand, and derives the flag input from both, so that both carry states meet every operand. Each expected byte and flag nibble is computed with multiply and divide arithmetic. Requests are issued back to back, and idle cycles are placed between them to show that outputs hold.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
  typedef enum logic [1:0] {
    GRP_SHIFT = 2'b00,
    GRP_TEST  = 2'b01,
    GRP_CLR   = 2'b10,
    GRP_SET   = 2'b11
  } grp_e;

  typedef enum logic [2:0] {
    SH_ROL  = 3'd0,
    SH_ROR  = 3'd1,
    SH_RCL  = 3'd2,
    SH_RCR  = 3'd3,
    SH_SHL  = 3'd4,
    SH_ASR  = 3'd5,
    SH_SWAP = 3'd6,
    SH_LSR  = 3'd7
  } shift_e;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } flags_t;

  localparam int unsigned OPC_W = 8;
endpackage

// File: rtl/bitop_shift.sv
module bitop_shift
  import bitop_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  shift_e            sel_i,
  input  logic [DATA_W-1:0] val_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cout_o
);
  localparam int unsigned HALF_W = DATA_W / 2;

  always_comb begin
    res_o  = val_i;
    cout_o = 1'b0;
    unique case (sel_i)
      SH_ROL:  begin res_o = {val_i[DATA_W-2:0], val_i[DATA_W-1]}; cout_o = val_i[DATA_W-1]; end
      SH_ROR:  begin res_o = {val_i[0], val_i[DATA_W-1:1]};        cout_o = val_i[0];        end
      SH_RCL:  begin res_o = {val_i[DATA_W-2:0], cin_i};           cout_o = val_i[DATA_W-1]; end
      SH_RCR:  begin res_o = {cin_i, val_i[DATA_W-1:1]};           cout_o = val_i[0];        end
      SH_SHL:  begin res_o = {val_i[DATA_W-2:0], 1'b0};            cout_o = val_i[DATA_W-1]; end
      SH_ASR:  begin res_o = {val_i[DATA_W-1], val_i[DATA_W-1:1]}; cout_o = val_i[0];        end
      SH_SWAP: begin res_o = {val_i[HALF_W-1:0], val_i[DATA_W-1:HALF_W]}; cout_o = 1'b0;     end
      SH_LSR:  begin res_o = {1'b0, val_i[DATA_W-1:1]};            cout_o = val_i[0];        end
      default: ;
    endcase
  end

  // swap never produces a carry
  always_comb begin
    if (sel_i == SH_SWAP) assert (!cout_o); // R6
  end
endmodule

// File: rtl/bitop_field.sv
module bitop_field
  import bitop_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned IDX_W = $clog2(DATA_W)
) (
  input  grp_e              grp_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] val_i,
  output logic [DATA_W-1:0] res_o,
  output logic              bit_o
);
  logic [DATA_W-1:0] mask;

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign mask[i] = (idx_i == IDX_W'(i));
  end

  assign bit_o = |(val_i & mask);

  always_comb begin
    unique case (grp_i)
      GRP_SET: res_o = val_i | mask;
      GRP_CLR: res_o = val_i & ~mask;
      default: res_o = val_i;
    endcase
  end

  always_comb begin
    if (grp_i == GRP_SET || grp_i == GRP_CLR)
      assert ($countones(res_o ^ val_i) <= 1); // R8
  end
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [7:0]        opcode_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic [3:0]        flags_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic              wb_en_o,
  output logic [3:0]        flags_o
);
  localparam int unsigned IDX_W = $clog2(DATA_W);

  grp_e              grp;
  logic [2:0]        field;
  logic [2:0]        unused_reg_sel;
  flags_t            f_in, f_nxt;
  logic [DATA_W-1:0] sh_res, bf_res, res_nxt;
  logic              sh_cout, bf_bit, wb_nxt;

  assign grp            = grp_e'(opcode_i[7:6]);
  assign field          = opcode_i[5:3];
  assign unused_reg_sel = opcode_i[2:0];
  assign f_in           = flags_t'(flags_i);

  bitop_shift #(.DATA_W(DATA_W)) u_shift (
    .sel_i (shift_e'(field)),
    .val_i (operand_i),
    .cin_i (f_in.c),
    .res_o (sh_res),
    .cout_o(sh_cout)
  );

  bitop_field #(.DATA_W(DATA_W)) u_field (
    .grp_i(grp),
    .idx_i(field[IDX_W-1:0]),
    .val_i(operand_i),
    .res_o(bf_res),
    .bit_o(bf_bit)
  );

  always_comb begin
    f_nxt   = f_in;
    res_nxt = bf_res;
    wb_nxt  = 1'b1;
    unique case (grp)
      GRP_SHIFT: begin
        res_nxt = sh_res;
        f_nxt   = '{z: (sh_res == '0), n: 1'b0, h: 1'b0, c: sh_cout};
      end
      GRP_TEST: begin
        wb_nxt = 1'b0;
        f_nxt  = '{z: ~bf_bit, n: 1'b0, h: 1'b1, c: f_in.c};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      wb_en_o  <= 1'b0;
      result_o <= '0;
      flags_o  <= '0;
    end else begin
      valid_o <= valid_i;
      wb_en_o <= valid_i & wb_nxt;
      if (valid_i) begin
        result_o <= res_nxt;
        flags_o  <= f_nxt;
      end
    end
  end

  AST_SHIFT_NH_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && opcode_i[7:6] == 2'b00 |=> !flags_o[2] && !flags_o[1]); // R5
  AST_TEST_NO_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && opcode_i[7:6] == 2'b01 |=> !wb_en_o && flags_o[1] && !flags_o[2]
      && flags_o[0] == $past(flags_i[0])); // R7
  AST_SETCLR_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && opcode_i[7] |=> wb_en_o && flags_o == $past(flags_i)); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && !wb_en_o && $stable(result_o) && $stable(flags_o)); // R10
  AST_VALID_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R9
endmodule

// File: tb/tb_bitop_unit.sv
module tb_bitop_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [7:0] opcode_i = '0;
  logic [7:0] operand_i = '0;
  logic [3:0] flags_i = '0;
  logic       valid_o, wb_en_o;
  logic [7:0] result_o;
  logic [3:0] flags_o;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitop_unit dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .opcode_i(opcode_i),
    .operand_i(operand_i), .flags_i(flags_i), .valid_o(valid_o),
    .result_o(result_o), .wb_en_o(wb_en_o), .flags_o(flags_o)
  );

  task automatic chk(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // packed compare word: {valid, wb, flags, result}
  function automatic int pack_out(int v, int wb, int f, int r);
    return v * 8192 + wb * 4096 + f * 256 + r;
  endfunction

  function automatic string tag_of(int op);
    int g = op / 64;
    int n = (op / 8) % 8;
    if (g == 1) return "R7";
    if (g >= 2) return "R8";
    if (n < 2) return "R2/R5";
    if (n < 4) return "R3/R5";
    if (n == 6) return "R6";
    return "R4/R5";
  endfunction

  // expected {wb, flags, result} per R1..R8
  function automatic int model(int op, int x, int f);
    int g = op / 64;
    int n = (op / 8) % 8;
    int cin = f % 2;
    int hi = x / 128;
    int lo = x % 2;
    int r = x, c = 0, z, bitv, p;
    p = 1 << n;
    case (g)
      0: begin
        case (n)
          0: begin r = (x * 2) % 256 + hi;  c = hi; end
          1: begin r = x / 2 + lo * 128;    c = lo; end
          2: begin r = (x * 2) % 256 + cin; c = hi; end
          3: begin r = x / 2 + cin * 128;   c = lo; end
          4: begin r = (x * 2) % 256;       c = hi; end
          5: begin r = x / 2 + hi * 128;    c = lo; end
          6: begin r = (x % 16) * 16 + x / 16; c = 0; end
          default: begin r = x / 2;         c = lo; end
        endcase
        z = (r == 0) ? 1 : 0;
        return 4096 + (z * 8 + c) * 256 + r;
      end
      1: begin
        bitv = (x / p) % 2;
        return ((1 - bitv) * 8 + 2 + cin) * 256 + x;
      end
      2: begin
        bitv = (x / p) % 2;
        return 4096 + f * 256 + (x - bitv * p);
      end
      default: begin
        bitv = (x / p) % 2;
        return 4096 + f * 256 + (x + (1 - bitv) * p);
      end
    endcase
  endfunction

  task automatic issue(int op, int x, int f);
    @(negedge clk);
    valid_i = 1'b1; opcode_i = 8'(op); operand_i = 8'(x); flags_i = 4'(f);
    @(posedge clk); #1;
    // R9: result is visible one edge after the request
    chk(tag_of(op), pack_out(valid_o, wb_en_o, flags_o, result_o), 8192 + model(op, x, f));
  endtask

  task automatic idle(int op, int x, int f);
    int held;
    held = pack_out(0, 0, flags_o, result_o);
    @(negedge clk);
    valid_i = 1'b0; opcode_i = 8'(op); operand_i = 8'(x); flags_i = 4'(f);
    @(posedge clk); #1;
    chk("R10", pack_out(valid_o, wb_en_o, flags_o, result_o), held);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got %0d cycles expected <= %0d", cycles, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11", pack_out(valid_o, wb_en_o, flags_o, result_o), 0);
    rst_ni = 1'b1;
    // directed corners: carry in differs from the bit shifted out
    issue(8'h10, 8'h00, 1);   // R3 rotate left through carry, C=1 into bit 0
    issue(8'h18, 8'h01, 0);   // R3 rotate right, bit 0 out, Z set
    issue(8'h28, 8'h81, 0);   // R4 arithmetic right keeps bit 7
    issue(8'h30, 8'h00, 15);  // R6 swap of zero
    issue(8'h7C, 8'h7F, 1);   // R7 bit 7 clear -> Z
    idle(8'hFF, 8'h00, 0);    // R10
    idle(8'h00, 8'hFF, 15);   // R10
    // R1: full sweep of group/field/register-select against every operand
    for (int op = 0; op < 256; op++) begin
      for (int x = 0; x < 256; x++) begin
        issue(op, x, (op * 7 + x * 3 + x / 16) % 16);
      end
      if (op % 64 == 63) idle(op, 0, 0);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule